// File: doc/BRIEF.md
# Converter Master Serial Readout Controller

This block is the digital side of a 16-bit successive-approximation converter that streams its results over a serial link it clocks itself. A rising edge on the start input begins a conversion. The conversion is modelled as a busy window of a fixed number of system clock cycles. At the end of that window the block captures the converter's result word. The block drives a serial clock at half the system clock rate, a framing signal that marks valid data, and one data line that carries the word most significant bit first.

A mode input picks one of two read orders. In the post-conversion order, the freshly captured word is sent after the busy window, and busy stays high until the last bit has gone out. In the overlapped order, the word from the previous conversion is sent at the start of the new busy window, so serial activity stays clear of the end of the conversion. Two configuration inputs invert the serial clock and the framing signal. A clock-source input set high stops the block from acting as master. Conversions still run in that case, but no frame is produced.

Top module: `sar_serial_master`

## Requirements
- R1: After a synchronous active-high reset, busy is 0, sdata is 0, the sclk pin equals inv_sclk and the sync pin equals inv_sync.
- R2: A 0-to-1 change of conv_start while busy is low raises busy at the next clock edge. In overlapped mode (rd_during=1), and whenever ext_clk_sel=1, busy then stays high for exactly CONV_CYCLES cycles.
- R3: Rising edges of conv_start while busy is high are ignored, and the busy width does not change. A level held high starts only one conversion.
- R4: In post-conversion mode (rd_during=0), the frame begins in the cycle the conversion ends and carries the word present on result_in at that point. Busy falls in the same cycle as the frame end, so busy lasts CONV_CYCLES + 2*DATA_W cycles.
- R5: In overlapped mode, the frame begins in the same cycle busy rises and carries the word captured by the preceding conversion. When no conversion has completed since reset, it carries all zeros.
- R6: A frame carries DATA_W bits, MSB first, one bit per sclk period of two system cycles. With inv_sclk=0, sdata changes only when sclk falls, and the receiver samples it on the rising sclk edge, giving exactly DATA_W rising edges per frame.
- R7: With inv_sync=0, sync is high for exactly 2*DATA_W consecutive cycles covering all bits, and busy is high throughout. With inv_sclk=0, sclk is low whenever sync is inactive.
- R8: inv_sclk=1 makes the sclk pin the complement of its default waveform. inv_sync=1 does the same for sync. Neither input changes timing or data.
- R9: With ext_clk_sel=1 at the start of a conversion, no frame is produced. sclk stays at its idle level and sync stays inactive, but the result is still captured and is sent by the next overlapped frame.
- R10: Reset clears the stored previous word, so the first overlapped frame after reset is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| conv_start | input | 1 | Conversion request, acted on at its rising edge |
| ext_clk_sel | input | 1 | 1 disables master framing; 0 makes the block clock the link |
| rd_during | input | 1 | 1 selects overlapped readout of the previous word; 0 selects post-conversion readout |
| inv_sclk | input | 1 | Inverts the serial clock pin |
| inv_sync | input | 1 | Inverts the framing pin |
| result_in | input | DATA_W | Converter result, captured when the conversion ends |
| busy | output | 1 | Conversion (and, in post-conversion mode, readout) in progress |
| sclk | output | 1 | Serial clock, half the system rate during a frame |
| sync | output | 1 | Frame marker, active while data bits are valid |
| sdata | output | 1 | Serial data, MSB first |

## Verification
The bench sweeps both read orders under all four polarity settings with many computed words. It rebuilds each frame from the pins and compares it with a word the bench tracks itself. The first overlapped frame after reset must be zero; a design that failed to clear its stored word would send stale data there. Busy width is measured in each mode: a design that dropped busy at the end of the conversion in post-conversion mode would come up 32 cycles short, and one that restarted on a mid-conversion or held start would stretch busy or fire again. The bench also checks that a frame disabled by the clock-source input still stores its word: a design that skipped the capture would replay an older word in the following overlapped frame.

// File: rtl/sar_ser_pkg.sv
package sar_ser_pkg;

  // Phase of the serial frame generator.
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } frame_phase_e;

  // Read order selected at the start of each conversion.
  typedef enum logic {
    RM_AFTER  = 1'b0,
    RM_DURING = 1'b1
  } read_mode_e;

endpackage

// File: rtl/sar_conv_timer.sv
module sar_conv_timer #(
  parameter int CONV_CYCLES = 40
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic active,
  output logic done
);
  localparam int CW = $clog2(CONV_CYCLES + 1);

  logic [CW-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      remain <= '0;
    end else if (start && !active) begin
      active <= 1'b1;
      remain <= CW'(CONV_CYCLES - 1);
    end else if (active) begin
      if (remain == '0) active <= 1'b0;
      else              remain <= remain - 1'b1;
    end
  end

  // Last cycle of the conversion window.
  assign done = active && (remain == '0);

endmodule

// File: rtl/sar_frame_shifter.sv
module sar_frame_shifter
  import sar_ser_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] word,
  output logic              sclk_raw,
  output logic              sync_raw,
  output logic              sdo,
  output logic              frame_done
);
  localparam int BW = $clog2(DATA_W);
  localparam logic [BW-1:0] LAST_BIT = BW'(DATA_W - 1);

  frame_phase_e      phase;
  logic [DATA_W-1:0] sreg;
  logic [BW-1:0]     bit_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      sreg     <= '0;
      bit_idx  <= '0;
      sclk_raw <= 1'b0;
      sync_raw <= 1'b0;
      sdo      <= 1'b0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (load) begin
            sdo      <= word[DATA_W-1];
            sreg     <= {word[DATA_W-2:0], 1'b0};
            bit_idx  <= '0;
            sync_raw <= 1'b1;
            sclk_raw <= 1'b0;
            phase    <= PH_LOW;
          end
        end
        PH_LOW: begin
          // Rising edge: receiver samples the bit on sdo.
          sclk_raw <= 1'b1;
          phase    <= PH_HIGH;
        end
        PH_HIGH: begin
          // Falling edge: next bit goes out, or the frame closes.
          sclk_raw <= 1'b0;
          if (bit_idx == LAST_BIT) begin
            sync_raw <= 1'b0;
            sdo      <= 1'b0;
            phase    <= PH_IDLE;
          end else begin
            sdo     <= sreg[DATA_W-1];
            sreg    <= {sreg[DATA_W-2:0], 1'b0};
            bit_idx <= bit_idx + 1'b1;
            phase   <= PH_LOW;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign frame_done = (phase == PH_HIGH) && (bit_idx == LAST_BIT);

endmodule

// File: rtl/sar_serial_master.sv
module sar_serial_master
  import sar_ser_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int CONV_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              conv_start,
  input  logic              ext_clk_sel,
  input  logic              rd_during,
  input  logic              inv_sclk,
  input  logic              inv_sync,
  input  logic [DATA_W-1:0] result_in,
  output logic              busy,
  output logic              sclk,
  output logic              sync,
  output logic              sdata
);
  logic              start_q;
  logic              busy_r;
  read_mode_e        mode_q;
  logic              frame_en_q;
  logic [DATA_W-1:0] prev_word;
  logic              start_ok;
  logic              conv_active;
  logic              conv_done;
  logic              frame_load;
  logic [DATA_W-1:0] frame_word;
  logic              sclk_raw;
  logic              sync_raw;
  logic              sdo;
  logic              frame_done;

  // Rising-edge detection of the request, accepted only while idle.
  always_ff @(posedge clk) begin
    if (rst) start_q <= 1'b0;
    else     start_q <= conv_start;
  end

  assign start_ok = conv_start && !start_q && !busy_r;

  sar_conv_timer #(
    .CONV_CYCLES(CONV_CYCLES)
  ) u_timer (
    .clk    (clk),
    .rst    (rst),
    .start  (start_ok),
    .active (conv_active),
    .done   (conv_done)
  );

  // Per-conversion configuration and the stored result.
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q     <= RM_AFTER;
      frame_en_q <= 1'b0;
      prev_word  <= '0;
    end else begin
      if (start_ok) begin
        mode_q     <= rd_during ? RM_DURING : RM_AFTER;
        frame_en_q <= !ext_clk_sel;
      end
      if (conv_done) prev_word <= result_in;
    end
  end

  // Overlapped frames load at the start; post-conversion frames at the end.
  assign frame_load = (start_ok && rd_during && !ext_clk_sel) ||
                      (conv_done && (mode_q == RM_AFTER) && frame_en_q);
  assign frame_word = start_ok ? prev_word : result_in;

  sar_frame_shifter #(
    .DATA_W(DATA_W)
  ) u_shift (
    .clk        (clk),
    .rst        (rst),
    .load       (frame_load),
    .word       (frame_word),
    .sclk_raw   (sclk_raw),
    .sync_raw   (sync_raw),
    .sdo        (sdo),
    .frame_done (frame_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_r <= 1'b0;
    end else if (start_ok) begin
      busy_r <= 1'b1;
    end else if (conv_done && ((mode_q == RM_DURING) || !frame_en_q)) begin
      busy_r <= 1'b0;
    end else if (frame_done && (mode_q == RM_AFTER)) begin
      busy_r <= 1'b0;
    end
  end

  assign busy  = busy_r;
  assign sclk  = sclk_raw ^ inv_sclk;
  assign sync  = sync_raw ^ inv_sync;
  assign sdata = sdo;

endmodule

// File: rtl/sar_serial_master_chk.sv
module sar_serial_master_chk #(
  parameter int DATA_W      = 16,
  parameter int CONV_CYCLES = 40
) (
  input logic clk,
  input logic rst,
  input logic conv_start,
  input logic inv_sclk,
  input logic inv_sync,
  input logic busy,
  input logic sclk,
  input logic sync,
  input logic sdata
);
  localparam int LW = $clog2(2 * DATA_W + 2);

  logic          sync_act;
  logic          sclk_lvl;
  logic          cs_q;
  logic [LW-1:0] sync_len;

  assign sync_act = sync ^ inv_sync;
  assign sclk_lvl = sclk ^ inv_sclk;

  always_ff @(posedge clk) begin
    if (rst) cs_q <= 1'b0;
    else     cs_q <= conv_start;
  end

  always_ff @(posedge clk) begin
    if (rst)           sync_len <= '0;
    else if (sync_act) sync_len <= sync_len + 1'b1;
    else               sync_len <= '0;
  end

  // R2: an accepted request raises busy on the next edge.
  a_r2_busy_rises: assert property (@(posedge clk) disable iff (rst)
    (!busy && conv_start && !cs_q) |=> busy);

  // R7: the frame never extends past busy.
  a_r7_frame_in_busy: assert property (@(posedge clk) disable iff (rst)
    sync_act |-> busy);

  // R7: frame length in system cycles.
  a_r7_sync_len: assert property (@(posedge clk) disable iff (rst)
    $fell(sync_act) |-> (sync_len == LW'(2 * DATA_W)));

  // R7: the serial clock rests at its idle level outside a frame.
  a_r7_sclk_idle: assert property (@(posedge clk) disable iff (rst)
    !sync_act |-> !sclk_lvl);

  // R6: inside a frame, data moves only on the falling clock edge.
  a_r6_data_on_fall: assert property (@(posedge clk) disable iff (rst)
    (sync_act && $past(sync_act) && (sdata != $past(sdata))) |-> $past(sclk_lvl));

endmodule

bind sar_serial_master sar_serial_master_chk #(
  .DATA_W      (DATA_W),
  .CONV_CYCLES (CONV_CYCLES)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .conv_start (conv_start),
  .inv_sclk   (inv_sclk),
  .inv_sync   (inv_sync),
  .busy       (busy),
  .sclk       (sclk),
  .sync       (sync),
  .sdata      (sdata)
);

// File: tb/test_sar_serial_master.sv
module test_sar_serial_master;
  localparam int CLK_PERIOD = 10;
  localparam int W          = 16;
  localparam int CONV       = 40;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         conv_start = 1'b0;
  logic         ext_clk_sel = 1'b0;
  logic         rd_during = 1'b0;
  logic         inv_sclk = 1'b0;
  logic         inv_sync = 1'b0;
  logic [W-1:0] result_in = '0;
  logic         busy, sclk, sync, sdata;

  int n_chk = 0;
  int n_fail = 0;
  bit reported = 1'b0;
  logic [W-1:0] model_prev = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sar_serial_master #(.DATA_W(W), .CONV_CYCLES(CONV)) i_sar_serial_master (
    .clk(clk), .rst(rst), .conv_start(conv_start), .ext_clk_sel(ext_clk_sel),
    .rd_during(rd_during), .inv_sclk(inv_sclk), .inv_sync(inv_sync),
    .result_in(result_in), .busy(busy), .sclk(sclk), .sync(sync), .sdata(sdata)
  );

  // Pin monitor, sampled at the falling system clock edge.
  int busy_cnt = 0, sync_cnt = 0, bit_cnt = 0, sync_off = 0, idle_bad = 0;
  logic [W-1:0] cap = '0;
  logic prev_sclk = 1'b0;

  always @(negedge clk) begin
    logic s_lvl, y_lvl;
    s_lvl = sclk ^ inv_sclk;
    y_lvl = sync ^ inv_sync;
    if (busy) busy_cnt++;
    if (y_lvl) begin
      if (sync_cnt == 0) sync_off = busy_cnt;
      sync_cnt++;
      if (s_lvl && !prev_sclk) begin
        cap = {cap[W-2:0], sdata};
        bit_cnt++;
      end
    end else if (s_lvl) begin
      idle_bad++;
    end
    prev_sclk = s_lvl;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!reported) begin
      reported = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    end
  endtask

  // Polarity changes and counter clears happen on the rising edge.
  task automatic clr(input bit isc, input bit isy);
    @(posedge clk);
    inv_sclk = isc;
    inv_sync = isy;
    busy_cnt = 0; sync_cnt = 0; bit_cnt = 0; sync_off = 0; idle_bad = 0;
    cap = '0;
  endtask

  task automatic run_conv(input bit mode, input bit ext, input logic [W-1:0] val,
                          input bit isc, input bit isy, input bit poke);
    logic [W-1:0] exp_word;
    int exp_busy;
    @(negedge clk);
    rd_during = mode; ext_clk_sel = ext; result_in = val;
    clr(isc, isy);
    @(negedge clk) conv_start = 1'b1;
    @(negedge clk) conv_start = 1'b0;
    if (poke) begin
      repeat (5) @(negedge clk);
      conv_start = 1'b1;
      @(negedge clk) conv_start = 1'b0;
    end
    for (int i = 0; i < 300 && busy; i++) @(negedge clk);
    @(negedge clk);
    exp_word = mode ? model_prev : val;
    exp_busy = (mode || ext) ? CONV : CONV + 2 * W;
    if (poke) chk("R3 busy width with extra request", busy_cnt, exp_busy);
    else if (mode || ext) chk("R2 busy width", busy_cnt, exp_busy);
    else chk("R4 busy width", busy_cnt, exp_busy);
    if (ext) begin
      chk("R9 no frame sync", sync_cnt, 0);
      chk("R9 no frame clocks", bit_cnt, 0);
    end else begin
      if (mode) begin
        chk("R5 word", cap, exp_word);
        chk("R5 frame start", sync_off, 1);
      end else begin
        chk("R4 word", cap, exp_word);
        chk("R4 frame start", sync_off, CONV + 1);
      end
      chk("R6 bit count", bit_cnt, W);
      chk("R7 sync length", sync_cnt, 2 * W);
    end
    chk("R7 sclk idle outside frame", idle_bad, 0);
    chk("R8 sclk idle pin", sclk, isc);
    chk("R8 sync idle pin", sync, isy);
    model_prev = val;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [W-1:0] v;
    // R1: reset state with default polarity
    repeat (3) @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 sdata", sdata, 0);
    chk("R1 sclk", sclk, 0);
    chk("R1 sync", sync, 0);
    clr(1'b1, 1'b1);
    @(negedge clk);
    chk("R1 sclk inverted", sclk, 1);
    chk("R1 sync inverted", sync, 1);
    rst = 1'b0;
    clr(1'b0, 1'b0);
    @(negedge clk);

    // R5 / R10: first overlapped frame after reset is zero
    run_conv(1'b1, 1'b0, 16'h1234, 1'b0, 1'b0, 1'b0);

    // Sweep: all polarities, both orders, computed words (R4 R5 R6 R7 R8)
    for (int p = 0; p < 4; p++) begin
      for (int m = 0; m < 2; m++) begin
        for (int k = 0; k < 4; k++) begin
          v = W'(32'h9E37 * (k + 1 + p * 4 + m * 16) + 32'h0101 * k);
          run_conv(m[0], 1'b0, v, p[0], p[1], 1'b0);
        end
      end
    end

    // Boundary words in both orders
    run_conv(1'b0, 1'b0, 16'hFFFF, 1'b0, 1'b0, 1'b0);
    run_conv(1'b1, 1'b0, 16'h0001, 1'b0, 1'b0, 1'b0);
    run_conv(1'b1, 1'b0, 16'h8000, 1'b1, 1'b0, 1'b0);
    run_conv(1'b0, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b0);
    run_conv(1'b1, 1'b0, 16'h7FFE, 1'b0, 1'b0, 1'b0);

    // R3: extra requests during busy are ignored
    run_conv(1'b0, 1'b0, 16'hC0DE, 1'b0, 1'b0, 1'b1);
    run_conv(1'b1, 1'b0, 16'h3A5A, 1'b0, 1'b0, 1'b1);

    // R3: a held level starts one conversion only
    @(negedge clk) rd_during = 1'b1; result_in = 16'h0F0F;
    clr(1'b0, 1'b0);
    @(negedge clk) conv_start = 1'b1;
    for (int i = 0; i < 300 && (busy || busy_cnt == 0); i++) @(negedge clk);
    repeat (10) @(negedge clk);
    chk("R3 held start no retrigger busy", busy, 0);
    chk("R3 held start single busy width", busy_cnt, CONV);
    conv_start = 1'b0;
    model_prev = 16'h0F0F;

    // R9: master disabled, word still captured
    run_conv(1'b1, 1'b1, 16'hABCD, 1'b0, 1'b0, 1'b0);
    run_conv(1'b0, 1'b1, 16'h5EED, 1'b1, 1'b1, 1'b0);
    run_conv(1'b1, 1'b0, 16'h1111, 1'b0, 1'b0, 1'b0);

    // R10: reset clears the stored word
    run_conv(1'b0, 1'b0, 16'hBEEF, 1'b0, 1'b0, 1'b0);
    @(negedge clk) rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model_prev = '0;
    run_conv(1'b1, 1'b0, 16'h2468, 1'b0, 1'b0, 1'b0);
    chk("R10 overlapped frame after reset", cap, 16'h0000);

    repeat (4) @(negedge clk);
    summary();
    $finish;
  end

endmodule